// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. A burst begins when either of two load strobes is sampled high: one comes from the processor side and one from the memory-controller side. Either strobe captures the external address. After that, the block forms each following address itself by stepping a small beat counter. The counter moves one step on each clock edge where the advance input is sampled high.

The order of the low address bits within a burst is chosen at load time. It is either linear, which counts up from the start offset with wrap-around, or interleaved, which XORs the start offset with the beat number. An order input tied low selects interleaved order, and so does the reset state. The address bits above the counter never change during a burst. Bursting is optional: a new address may be loaded on every cycle.

The outputs are registered state, so they show the result of the most recent rising edge. The asynchronous active-low reset is released in step with the clock.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held, `addr_o` is zero and `burst_act_o` is low.
- R2: If `cpu_ld_i` or `ctl_ld_i` (or both) is high at a rising edge, `addr_o` equals the `addr_i` sampled at that edge from that edge onward, and the beat number returns to 0.
- R3: Without a load strobe, the beat number goes up by one (modulo 2^BURST_BITS) at each edge where `adv_i` is high. At an edge where `adv_i` is low, `addr_o` holds its value.
- R4: In linear order, the low BURST_BITS bits of `addr_o` equal (start + n) mod 2^BURST_BITS. Here start is the low field of the loaded address and n is the beat number.
- R5: In interleaved order, the low BURST_BITS bits of `addr_o` equal start XOR n.
- R6: `lin_i` is sampled only with a load strobe (1 = linear, 0 = interleaved). Changing it during a burst has no effect on the sequence. After reset the order is interleaved.
- R7: The bits of `addr_o` above the low BURST_BITS field stay fixed from one load to the next, including across a wrap of the low field.
- R8: When a load strobe and `adv_i` are both high at the same edge, the load wins: the new address appears with beat 0.
- R9: `burst_act_o` is high after every load. It falls at the edge where an advance moves the beat number from its last value back to 0, and it stays low until the next load. Advances after that point keep wrapping the address.
- R10: Loads on consecutive edges each take effect at once, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ld_i | input | 1 | Processor-side burst load strobe |
| ctl_ld_i | input | 1 | Controller-side burst load strobe |
| adv_i | input | 1 | Step the burst beat counter |
| lin_i | input | 1 | Order select captured at load: 1 linear, 0 interleaved |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current word address |
| burst_act_o | output | 1 | Burst in progress, first pass through the beats |

## Verification
The bench builds the block with ADDR_W = 12 and the default BURST_BITS = 2. With those values all four start offsets can be swept in both orders, and a random upper field of ten bits is enough to show that the upper bits survive a wrap. A behavioural model written with integers predicts the address and the active flag at every clock. The stimulus covers both strobes alone and together, loads that coincide with advances, order flips during a burst, gaps between advances, and loads on back-to-back cycles.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_ILV = 1'b0,
    ORD_LIN = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BURST_BITS = 2,
  localparam int UP_W      = ADDR_W - BURST_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  lin_i,
  output logic [UP_W-1:0]       upper_o,
  output logic [BURST_BITS-1:0] start_o,
  output burst_order_e          order_o
);
  logic [UP_W-1:0]       upper_q, upper_d;
  logic [BURST_BITS-1:0] start_q, start_d;
  burst_order_e          order_q, order_d;

  always_comb begin
    upper_d = upper_q;
    start_d = start_q;
    order_d = order_q;
    if (load_i) begin
      upper_d = addr_i[ADDR_W-1:BURST_BITS];
      start_d = addr_i[BURST_BITS-1:0];
      order_d = lin_i ? ORD_LIN : ORD_ILV;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      order_q <= ORD_ILV;
    end else if (load_i) begin
      upper_q <= upper_d;
      start_q <= start_d;
      order_q <= order_d;
    end
  end

  assign upper_o = upper_q;
  assign start_o = start_q;
  assign order_o = order_q;

  // order only moves with a load
  assert_order_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(order_q));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BURST_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic                  adv_i,
  output logic [BURST_BITS-1:0] beat_o,
  output logic                  active_o
);
  localparam logic [BURST_BITS-1:0] BEAT_LAST = '1;
  localparam logic [BURST_BITS-1:0] BEAT_ONE  = BURST_BITS'(1);

  logic [BURST_BITS-1:0] beat_q, beat_d;
  logic                  act_q, act_d;
  logic                  ctr_en;

  assign ctr_en = load_i | adv_i;

  always_comb begin
    beat_d = beat_q;
    act_d  = act_q;
    if (load_i) begin
      beat_d = '0;
      act_d  = 1'b1;
    end else if (adv_i) begin
      beat_d = beat_q + BEAT_ONE;
      if (beat_q == BEAT_LAST) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      act_q  <= 1'b0;
    end else if (ctr_en) begin
      beat_q <= beat_d;
      act_q  <= act_d;
    end
  end

  assign beat_o   = beat_q;
  assign active_o = act_q;

  assert_act_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_i && beat_q == BEAT_LAST) |=> !active_o);
  assert_act_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (active_o && beat_o == '0));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BURST_BITS = 2
) (
  input  burst_order_e          order_i,
  input  logic [BURST_BITS-1:0] start_i,
  input  logic [BURST_BITS-1:0] beat_i,
  output logic [BURST_BITS-1:0] low_o
);
  logic [BURST_BITS-1:0] lin_w;
  logic [BURST_BITS-1:0] ilv_w;

  assign lin_w = start_i + beat_i;

  for (genvar b = 0; b < BURST_BITS; b++) begin : g_ilv
    assign ilv_w[b] = start_i[b] ^ beat_i[b];
  end

  assign low_o = (order_i == ORD_LIN) ? lin_w : ilv_w;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ld_i,
  input  logic              ctl_ld_i,
  input  logic              adv_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              burst_act_o
);
  localparam int UP_W = ADDR_W - BURST_BITS;
  localparam logic [BURST_BITS-1:0] LOW_ONE = BURST_BITS'(1);

  logic                  rst_n_s;
  logic                  load_w;
  logic [UP_W-1:0]       upper_w;
  logic [BURST_BITS-1:0] start_w;
  logic [BURST_BITS-1:0] beat_w;
  logic [BURST_BITS-1:0] low_w;
  logic [BURST_BITS-1:0] low_inc_w;
  burst_order_e          order_w;

  assign load_w = cpu_ld_i | ctl_ld_i;

  burst_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_areg (
    .clk(clk), .rst_n(rst_n_s), .load_i(load_w), .addr_i(addr_i),
    .lin_i(lin_i), .upper_o(upper_w), .start_o(start_w), .order_o(order_w)
  );

  burst_beat_ctr #(.BURST_BITS(BURST_BITS)) u_ctr (
    .clk(clk), .rst_n(rst_n_s), .load_i(load_w), .adv_i(adv_i),
    .beat_o(beat_w), .active_o(burst_act_o)
  );

  burst_order_map #(.BURST_BITS(BURST_BITS)) u_map (
    .order_i(order_w), .start_i(start_w), .beat_i(beat_w), .low_o(low_w)
  );

  assign addr_o    = {upper_w, low_w};
  assign low_inc_w = addr_o[BURST_BITS-1:0] + LOW_ONE;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    load_w |=> addr_o == $past(addr_i));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!load_w && !adv_i) |=> $stable(addr_o));
  assert_lin_step_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!load_w && adv_i && order_w == ORD_LIN)
      |=> addr_o[BURST_BITS-1:0] == $past(low_inc_w));
  assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !load_w |=> $stable(addr_o[ADDR_W-1:BURST_BITS]));
  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (load_w && adv_i) |=> addr_o[BURST_BITS-1:0] == $past(addr_i[BURST_BITS-1:0]));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 12;
  localparam int BB = 2;
  localparam int NB = 1 << BB;

  logic          clk;
  logic          rst_n;
  logic          cpu_ld, ctl_ld, adv, lin;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic          act_out;

  int checks;
  int errors;
  int cyc;
  string cur_req;

  // behavioural reference state
  int m_up, m_start, m_n, m_lin, m_act;

  burst_addr_seq #(.ADDR_W(AW), .BURST_BITS(BB)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .cpu_ld_i(cpu_ld), .ctl_ld_i(ctl_ld),
    .adv_i(adv), .lin_i(lin), .addr_i(addr_in), .addr_o(addr_out),
    .burst_act_o(act_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int exp_addr();
    int low;
    if (m_lin != 0) low = (m_start + m_n) % NB;
    else            low = m_start ^ m_n;
    return m_up * NB + low;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_up = 0; m_start = 0; m_n = 0; m_lin = 0; m_act = 0;
    end else if (cpu_ld || ctl_ld) begin
      m_up    = int'(addr_in) / NB;
      m_start = int'(addr_in) % NB;
      m_n     = 0;
      m_lin   = lin ? 1 : 0;
      m_act   = 1;
    end else if (adv) begin
      if (m_n == NB - 1) m_act = 0;
      m_n = (m_n + 1) % NB;
    end
  end

  always @(negedge clk) begin
    int ea;
    ea = exp_addr();
    checks++;
    if (int'(addr_out) !== ea) begin
      errors++;
      $display("FAIL %s addr_o actual %h expected %h", cur_req, addr_out, ea[AW-1:0]);
    end
    checks++;
    if (int'(act_out) !== m_act) begin
      errors++;
      $display("FAIL %s burst_act_o actual %0d expected %0d", cur_req, act_out, m_act);
    end
  end

  always @(posedge clk) begin
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 50000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(input logic c, input logic k, input logic a,
                       input logic l, input logic [AW-1:0] ad);
    @(negedge clk);
    #1;
    cpu_ld = c; ctl_ld = k; adv = a; lin = l; addr_in = ad;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, lin, addr_in);
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0;
    cpu_ld = 0; ctl_ld = 0; adv = 0; lin = 0; addr_in = '0;
    rst_n = 0;
    cur_req = "R1";                       // R1: reset values
    repeat (4) @(negedge clk);
    #2 rst_n = 1;
    idle(4);

    cur_req = "R2";                       // R2: each strobe loads alone and together
    drive(1, 0, 0, 0, 12'hA5C); idle(1);
    drive(0, 1, 0, 1, 12'h3F1); idle(1);
    drive(1, 1, 0, 0, 12'h77E); idle(1);

    // R4 / R5: every start offset in both orders, five advances to wrap (R9)
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < NB; s++) begin
        cur_req = (m != 0) ? "R4" : "R5";
        drive(s[0], ~s[0], 0, m[0], {10'($urandom), s[1:0]});
        for (int k = 0; k < NB + 1; k++) drive(0, 0, 1, ~m[0], addr_in);
        cur_req = "R9";
        drive(0, 0, 1, m[0], addr_in);
        idle(1);
      end
    end

    cur_req = "R3";                       // R3: gaps between advances hold the address
    drive(1, 0, 0, 1, 12'h402);
    for (int k = 0; k < 6; k++) begin
      drive(0, 0, 1, 1, addr_in);
      idle(2);
    end

    cur_req = "R6";                       // R6: order flips mid burst ignored
    drive(0, 1, 0, 0, 12'h9B3);
    for (int k = 0; k < NB; k++) drive(0, 0, 1, k[0], addr_in);
    idle(1);

    cur_req = "R7";                       // R7: upper field survives wraps
    for (int t = 0; t < 6; t++) begin
      drive(1, 0, 0, t[0], 12'($urandom));
      for (int k = 0; k < 2 * NB + 1; k++) drive(0, 0, 1, 0, 12'($urandom));
    end

    cur_req = "R8";                       // R8: load wins over advance
    drive(1, 0, 0, 1, 12'h101);
    drive(0, 0, 1, 1, addr_in);
    drive(0, 1, 1, 1, 12'h222);
    drive(1, 0, 1, 0, 12'h333);
    drive(0, 0, 1, 0, addr_in);
    idle(1);

    cur_req = "R10";                      // R10: load on every cycle
    for (int k = 0; k < 8; k++) drive(k[0], ~k[0], k[1], k[2], 12'($urandom));
    idle(2);

    cur_req = "R1";                       // R1: reset mid burst
    drive(1, 0, 0, 1, 12'hFFF);
    drive(0, 0, 1, 1, addr_in);
    @(negedge clk); #2 rst_n = 0;
    idle(3);
    @(negedge clk); #2 rst_n = 1;
    drive(0, 0, 0, 0, '0);
    idle(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule